// File: doc/BRIEF.md
# Rotating Tiled Framebuffer Address Generator

This block produces the byte address at which each output pixel of a scaling engine is stored. The engine delivers pixels in raster scan order, with x running fastest. For every pixel the block first applies a quarter-turn rotation to the scan coordinate. It then forms either a linear or an 8x8-tiled pixel index, multiplies that index by the bytes per pixel and adds a base address. One address is offered per cycle on a valid/ready handshake, and the final pixel of the frame carries a last flag.

A single-cycle `start` pulse samples the whole configuration: base address, width minus one, height minus one, pixel mode, rotation code and tiling enable. The sampled values stay fixed until the frame is complete. The controller has three states:

- `S_IDLE`: waiting for a start pulse.
- `S_RUN`: emitting addresses.
- `S_FAULT`: a tiled frame was requested with a dimension that is not a multiple of 8.

The transitions are:

- *go*: from `S_IDLE` or `S_FAULT` to `S_RUN`, on a start pulse with a valid configuration.
- *reject*: from `S_IDLE` or `S_FAULT` to `S_FAULT`, on a start pulse with tiling enabled and a bad dimension.
- *advance*: `S_RUN` stays in `S_RUN` on a handshake that is not the last.
- *finish*: from `S_RUN` to `S_IDLE`, on the handshake of the last pixel.

Top module: `fb_addr_gen`

## Requirements
- R1: After reset, `addr_valid`, `busy` and `cfg_err` are all 0.
- R2: A start pulse in `S_IDLE` or `S_FAULT` with a valid configuration raises `addr_valid` and `busy` in the following cycle. Configuration inputs and `start` are ignored while a frame is running.
- R3: A frame of width W and height H delivers exactly W*H handshakes. `addr_last` is 1 only on the final one.
- R4: With rotation code 0 and tiling off, the pixel at scan position (x,y) has address base + (y*W + x)*bpp.
- R5: Rotation code 1 (90° clockwise) stores pixel (x,y) at column H-1-y, row x. Rotation code 3 (270° clockwise) stores it at column y, row W-1-x. Both codes use a line stride of H pixels.
- R6: Rotation code 2 (180°) stores pixel (x,y) at column W-1-x, row H-1-y with a stride of W. This is a true rotation, not a mirror.
- R7: Pixel mode 0 uses 4 bytes per pixel, mode 1 uses 3, and modes 2 and 3 use 2.
- R8: With tiling on, the index of stored pixel (u,v) with stride S is ((v/8)*(S/8) + u/8)*64 + m. Here m interleaves the low bits so that bit 0 is u[0], bit 1 is v[0], bit 2 is u[1], bit 3 is v[1], bit 4 is u[2] and bit 5 is v[2].
- R9: A start pulse with tiling on and a width or height that is not a multiple of 8 sets `cfg_err` in the following cycle, and no address is offered. A later valid start clears `cfg_err`.
- R10: While `addr_valid` is 1 and `addr_ready` is 0, `addr` and `addr_last` hold their values.
- R11: After the last handshake, `addr_valid` and `busy` are 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Frame start pulse; samples the configuration |
| base_addr | input | ADDR_W | Framebuffer base byte address |
| width_m1 | input | XW | Output width minus one |
| height_m1 | input | YW | Output height minus one |
| pix_mode | input | 2 | Bytes-per-pixel code |
| rot_code | input | 2 | Rotation code: 0, 90, 180 or 270 degrees clockwise |
| tile_en | input | 1 | Enable 8x8 tiled layout |
| addr_valid | output | 1 | Address offered |
| addr_ready | input | 1 | Consumer accepts the address |
| addr | output | ADDR_W | Byte address of the current pixel |
| addr_last | output | 1 | Current pixel is the last of the frame |
| busy | output | 1 | A frame is in progress |
| cfg_err | output | 1 | Rejected tiled configuration |

## Verification
The hardest conditions to reach from the ports are a frame whose configuration inputs change under it, and a start pulse arriving in the middle of a frame. Both must leave the address sequence untouched.

The bench reaches them as follows. Once each frame has begun, it drives the configuration inputs to complemented values. In selected frames it also holds `start` high around the midpoint of the frame. Every handshake address is compared with an arithmetic model. The model covers all rotation codes, all pixel modes, both layouts and a throttled ready pattern.

// File: rtl/fb_pkg.sv
package fb_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_RUN   = 2'd1,
        S_FAULT = 2'd2
    } fb_state_e;

    typedef enum logic [1:0] {
        ROT_0   = 2'd0,
        ROT_90  = 2'd1,
        ROT_180 = 2'd2,
        ROT_270 = 2'd3
    } fb_rot_e;

    function automatic logic [2:0] bytes_per_pixel(input logic [1:0] mode);
        logic [2:0] b;
        unique case (mode)
            2'd0:    b = 3'd4;
            2'd1:    b = 3'd3;
            default: b = 3'd2;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/fb_scan_counter.sv
module fb_scan_counter #(
    parameter int XW = 9,
    parameter int YW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic [XW-1:0] xmax,
    input  logic [YW-1:0] ymax,
    output logic [XW-1:0] x,
    output logic [YW-1:0] y,
    output logic          at_end
);

    logic x_wrap;

    assign x_wrap = (x == xmax);
    assign at_end = x_wrap && (y == ymax);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x <= '0;
            y <= '0;
        end else if (clear) begin
            x <= '0;
            y <= '0;
        end else if (step) begin
            if (x_wrap) begin
                x <= '0;
                y <= at_end ? '0 : y + YW'(1);
            end else begin
                x <= x + XW'(1);
            end
        end
    end

endmodule

// File: rtl/fb_rot_map.sv
module fb_rot_map
    import fb_pkg::*;
#(
    parameter int XW = 9,
    parameter int YW = 10,
    parameter int CW = 10
) (
    input  logic [XW-1:0] x,
    input  logic [YW-1:0] y,
    input  logic [XW-1:0] wm1,
    input  logic [YW-1:0] hm1,
    input  logic [1:0]    rot,
    output logic [CW-1:0] u,
    output logic [CW-1:0] v,
    output logic [CW:0]   stride
);

    localparam int SWW = CW + 1;

    logic [SWW-1:0] w_pix;
    logic [SWW-1:0] h_pix;

    assign w_pix = SWW'(wm1) + SWW'(1);
    assign h_pix = SWW'(hm1) + SWW'(1);

    always_comb begin
        unique case (fb_rot_e'(rot))
            ROT_0: begin
                u      = CW'(x);
                v      = CW'(y);
                stride = w_pix;
            end
            ROT_90: begin
                u      = CW'(hm1 - y);
                v      = CW'(x);
                stride = h_pix;
            end
            ROT_180: begin
                u      = CW'(wm1 - x);
                v      = CW'(hm1 - y);
                stride = w_pix;
            end
            ROT_270: begin
                u      = CW'(y);
                v      = CW'(wm1 - x);
                stride = h_pix;
            end
            default: begin
                u      = '0;
                v      = '0;
                stride = w_pix;
            end
        endcase
    end

endmodule

// File: rtl/fb_addr_form.sv
module fb_addr_form #(
    parameter int ADDR_W = 32,
    parameter int CW     = 10,
    parameter int IDX_W  = 21
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [CW-1:0]     u,
    input  logic [CW-1:0]     v,
    input  logic [CW:0]       stride,
    input  logic [2:0]        bpp,
    input  logic              tile,
    output logic [ADDR_W-1:0] addr
);

    localparam int TB = 3;

    logic [2*TB-1:0]  morton;
    logic [IDX_W-1:0] lin_idx;
    logic [IDX_W-1:0] tile_row;
    logic [IDX_W-1:0] tile_id;
    logic [IDX_W-1:0] tile_idx;
    logic [IDX_W-1:0] idx;

    for (genvar i = 0; i < TB; i++) begin : g_interleave
        assign morton[2*i]   = u[i];
        assign morton[2*i+1] = v[i];
    end

    assign lin_idx  = IDX_W'(v) * IDX_W'(stride) + IDX_W'(u);
    assign tile_row = IDX_W'(v >> TB) * IDX_W'(stride >> TB);
    assign tile_id  = tile_row + IDX_W'(u >> TB);
    assign tile_idx = (tile_id << (2*TB)) | IDX_W'(morton);
    assign idx      = tile ? tile_idx : lin_idx;
    assign addr     = base + ADDR_W'(idx) * ADDR_W'(bpp);

endmodule

// File: rtl/fb_addr_gen.sv
module fb_addr_gen
    import fb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int XW     = 9,
    parameter int YW     = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [XW-1:0]     width_m1,
    input  logic [YW-1:0]     height_m1,
    input  logic [1:0]        pix_mode,
    input  logic [1:0]        rot_code,
    input  logic              tile_en,
    output logic              addr_valid,
    input  logic              addr_ready,
    output logic [ADDR_W-1:0] addr,
    output logic              addr_last,
    output logic              busy,
    output logic              cfg_err
);

    localparam int CW    = (XW > YW) ? XW : YW;
    localparam int IDX_W = XW + YW + 2;

    fb_state_e state, state_nxt;

    logic [ADDR_W-1:0] cfg_base;
    logic [XW-1:0]     cfg_wm1;
    logic [YW-1:0]     cfg_hm1;
    logic [2:0]        cfg_bpp;
    logic [1:0]        cfg_rot;
    logic              cfg_tile;

    logic          launch;
    logic          tile_ok;
    logic          hs;
    logic          at_end;
    logic [XW-1:0] sx;
    logic [YW-1:0] sy;
    logic [CW-1:0] su;
    logic [CW-1:0] sv;
    logic [CW:0]   stride;

    assign launch  = start && (state != S_RUN);
    assign tile_ok = !tile_en || ((&width_m1[2:0]) && (&height_m1[2:0]));
    assign hs      = addr_valid && addr_ready;

    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE, S_FAULT: begin
                if (start) state_nxt = tile_ok ? S_RUN : S_FAULT;
            end
            S_RUN: begin
                if (hs && at_end) state_nxt = S_IDLE;
            end
            default: state_nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_base <= '0;
            cfg_wm1  <= '0;
            cfg_hm1  <= '0;
            cfg_bpp  <= 3'd4;
            cfg_rot  <= '0;
            cfg_tile <= 1'b0;
        end else if (launch) begin
            cfg_base <= base_addr;
            cfg_wm1  <= width_m1;
            cfg_hm1  <= height_m1;
            cfg_bpp  <= bytes_per_pixel(pix_mode);
            cfg_rot  <= rot_code;
            cfg_tile <= tile_en;
        end
    end

    always_comb begin
        addr_valid = 1'b0;
        busy       = 1'b0;
        cfg_err    = 1'b0;
        unique case (state)
            S_IDLE:  ;
            S_RUN: begin
                addr_valid = 1'b1;
                busy       = 1'b1;
            end
            S_FAULT: cfg_err = 1'b1;
            default: ;
        endcase
        addr_last = addr_valid && at_end;
    end

    fb_scan_counter #(.XW(XW), .YW(YW)) u_scan (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (launch),
        .step   (hs),
        .xmax   (cfg_wm1),
        .ymax   (cfg_hm1),
        .x      (sx),
        .y      (sy),
        .at_end (at_end)
    );

    fb_rot_map #(.XW(XW), .YW(YW), .CW(CW)) u_rot (
        .x      (sx),
        .y      (sy),
        .wm1    (cfg_wm1),
        .hm1    (cfg_hm1),
        .rot    (cfg_rot),
        .u      (su),
        .v      (sv),
        .stride (stride)
    );

    fb_addr_form #(.ADDR_W(ADDR_W), .CW(CW), .IDX_W(IDX_W)) u_form (
        .base   (cfg_base),
        .u      (su),
        .v      (sv),
        .stride (stride),
        .bpp    (cfg_bpp),
        .tile   (cfg_tile),
        .addr   (addr)
    );

endmodule

// File: rtl/fb_addr_gen_chk.sv
module fb_addr_gen_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              tile_en,
    input logic              addr_valid,
    input logic              addr_ready,
    input logic [ADDR_W-1:0] addr,
    input logic              addr_last,
    input logic              busy,
    input logic              cfg_err
);

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid && !addr_ready |=> addr_valid && $stable(addr) && $stable(addr_last));

    // R3
    last_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_last |-> addr_valid);

    // R11
    end_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid && addr_ready && addr_last |=> !addr_valid && !busy);

    // R2
    valid_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_valid) |-> $past(start));

    // R9
    fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> $past(start) && $past(tile_en));

endmodule

bind fb_addr_gen fb_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .tile_en    (tile_en),
    .addr_valid (addr_valid),
    .addr_ready (addr_ready),
    .addr       (addr),
    .addr_last  (addr_last),
    .busy       (busy),
    .cfg_err    (cfg_err)
);

// File: tb/fb_addr_gen_tb.sv
`timescale 1ns/1ps
module fb_addr_gen_tb;

    localparam int ADDR_W = 32;
    localparam int XW     = 9;
    localparam int YW     = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] base_addr = '0;
    logic [XW-1:0]     width_m1 = '0;
    logic [YW-1:0]     height_m1 = '0;
    logic [1:0]        pix_mode = '0;
    logic [1:0]        rot_code = '0;
    logic              tile_en = 1'b0;
    logic              addr_valid;
    logic              addr_ready = 1'b0;
    logic [ADDR_W-1:0] addr;
    logic              addr_last;
    logic              busy;
    logic              cfg_err;

    int checks = 0;
    int failures = 0;
    int k = 0;

    always #4 clk = ~clk;

    fb_addr_gen #(.ADDR_W(ADDR_W), .XW(XW), .YW(YW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .base_addr  (base_addr),
        .width_m1   (width_m1),
        .height_m1  (height_m1),
        .pix_mode   (pix_mode),
        .rot_code   (rot_code),
        .tile_en    (tile_en),
        .addr_valid (addr_valid),
        .addr_ready (addr_ready),
        .addr       (addr),
        .addr_last  (addr_last),
        .busy       (busy),
        .cfg_err    (cfg_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint model_addr(input int x, input int y, input int w, input int h,
                                          input int rot, input int mode, input bit tile,
                                          input longint base);
        int u, v, s, bpp;
        longint idx;
        int m;
        case (rot)
            0: begin u = x;         v = y;         s = w; end
            1: begin u = h - 1 - y; v = x;         s = h; end
            2: begin u = w - 1 - x; v = h - 1 - y; s = w; end
            default: begin u = y;   v = w - 1 - x; s = h; end
        endcase
        bpp = (mode == 0) ? 4 : (mode == 1) ? 3 : 2;
        if (tile) begin
            m = (u & 1) | ((v & 1) << 1) | (((u >> 1) & 1) << 2) |
                (((v >> 1) & 1) << 3) | (((u >> 2) & 1) << 4) | (((v >> 2) & 1) << 5);
            idx = (longint'((v / 8) * (s / 8) + u / 8)) * 64 + m;
        end else begin
            idx = longint'(v) * s + u;
        end
        return (base + idx * bpp) & 64'hFFFF_FFFF;
    endfunction

    task automatic run_frame(input int w, input int h, input int rot, input int mode,
                             input bit tile, input longint base, input bit midstart);
        int total, n, guard;
        bit pend, rdy;
        logic [ADDR_W-1:0] hold;
        string tag;
        total = w * h;
        tag = tile ? "R8" : (rot == 0) ? "R4" : (rot == 2) ? "R6" : "R5";
        @(negedge clk);
        base_addr = ADDR_W'(base);
        width_m1  = XW'(w - 1);
        height_m1 = YW'(h - 1);
        pix_mode  = 2'(mode);
        rot_code  = 2'(rot);
        tile_en   = tile;
        start     = 1'b1;
        addr_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        check(addr_valid && busy, "R2", "valid after start", addr_valid, 1);
        check(!cfg_err, "R9", "err clear after good start", cfg_err, 0);
        // configuration changes mid-frame must be ignored (R2)
        base_addr = ~base_addr;
        width_m1  = ~width_m1;
        height_m1 = ~height_m1;
        pix_mode  = ~pix_mode;
        rot_code  = ~rot_code;
        tile_en   = ~tile_en;
        n = 0; guard = 0; pend = 0; hold = '0;
        while (n < total && guard < 4 * total + 50) begin
            if (pend) begin
                check(addr_valid && addr == hold, "R10", "held address", addr, hold);
                pend = 0;
            end
            rdy = ((k * 7) % 5) != 0;
            k++;
            start = (midstart && n == total / 2);
            addr_ready = rdy;
            if (addr_valid) begin
                if (rdy) begin
                    longint e;
                    e = model_addr(n % w, n / w, w, h, rot, mode, tile, base);
                    check(addr == ADDR_W'(e), {tag, " R7"}, "pixel address", addr, e);
                    check(addr_last == (n == total - 1), "R3", "last flag", addr_last,
                          longint'(n == total - 1));
                    n++;
                end else begin
                    pend = 1;
                    hold = addr;
                end
            end
            @(negedge clk);
            guard++;
        end
        start = 1'b0;
        addr_ready = 1'b0;
        check(n == total, "R3", "handshake count", n, total);
        check(!addr_valid && !busy, "R11", "idle after last", addr_valid, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!addr_valid && !busy && !cfg_err, "R1", "reset outputs",
              {addr_valid, busy, cfg_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!addr_valid && !busy && !cfg_err, "R1", "after reset release",
              {addr_valid, busy, cfg_err}, 0);

        for (int r = 0; r < 4; r++) begin
            for (int m = 0; m < 4; m++) begin
                run_frame(1, 1, r, m, 1'b0, 64'h100, 1'b0);
                run_frame(3, 5, r, m, 1'b0, 64'h1000 + m * 4, (m == 1));
                run_frame(8, 16, r, m, 1'b0, 64'h2000, 1'b0);
                run_frame(16, 8, r, m, 1'b1, 64'h8000, (m == 2));
                run_frame(8, 16, r, m, 1'b1, 64'h4_0000, 1'b0);
            end
        end
        run_frame(512, 1, 1, 0, 1'b0, 64'hFFFF_0000, 1'b0);
        run_frame(1, 512, 3, 2, 1'b0, 64'h0, 1'b1);
        run_frame(24, 16, 2, 1, 1'b1, 64'h10, 1'b0);

        // rejected tiled configuration (R9)
        @(negedge clk);
        width_m1 = XW'(11); height_m1 = YW'(7); tile_en = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(cfg_err && !addr_valid, "R9", "bad width rejected", cfg_err, 1);
        repeat (3) @(negedge clk);
        check(cfg_err && !addr_valid && !busy, "R9", "no addresses in fault",
              addr_valid, 0);
        width_m1 = XW'(7); height_m1 = YW'(4);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(cfg_err && !addr_valid, "R9", "bad height rejected", cfg_err, 1);
        run_frame(8, 8, 0, 0, 1'b1, 64'h0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule